// File: doc/BRIEF.md
# PWM Drive Permit with Overcurrent Hold

This block decides, on every clock, whether the downstream commutation decoder may switch its power stage on. Three conditions must all agree. A free-running sawtooth counter, compared against a speed command word, sets the duty cycle. An externally chopped enable input must be high. No overcurrent may be pending. The result is a single drive-permit bit, with the state of the overcurrent hold exposed beside it.

An overcurrent flag from an external digital comparator is sampled continuously. Any sample that is asserted sets a sticky hold, and that hold blocks drive at once. The hold can be released only at a qualifying rising edge: either the sawtooth wrapping back to zero or a rising edge of the enable input. Release happens only if overcurrent has already gone away at that edge. Retries after a fault therefore happen no faster than the chop rate. While brake is asserted, the overcurrent flag is ignored, so a braking winding short cannot latch a fault.

Top module: `pwm_oc_gate`

## Requirements
- R1: After reset, the sawtooth counter is 0 and the overcurrent hold is clear. In the first cycle after reset release, `drive_ok` is 0 for any speed command, because 0 is not greater than any command.
- R2: The sawtooth counter advances by one on each clock and wraps from all-ones to 0. `drive_ok` can be 1 only while `speed_cmd` is strictly less than the counter value.
- R3: `enable_in` passes through a two-flop synchronizer. Drive is blocked while the synchronized enable is low.
- R4: `oc_flag` passes through a two-flop synchronizer. A synchronized high that is not masked by brake blocks `drive_ok` in the same cycle. It also sets `oc_latched` at the next clock edge.
- R5: Once set, `oc_latched` stays set until a clock edge on which the counter goes from all-ones to 0, or on which the synchronized enable is high after being low on the previous edge.
- R6: If the unmasked synchronized overcurrent is still high at a clearing edge, `oc_latched` stays set. Release waits for a later clearing edge at which it is low.
- R7: While `brake` is 1, the overcurrent input neither sets the hold nor blocks drive.
- R8: A `speed_cmd` of all-ones never permits drive. A `speed_cmd` of 0 permits drive on every counter value except 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_cmd | input | CNT_W | Speed command compared against the sawtooth |
| enable_in | input | 1 | Chop enable, asynchronous |
| oc_flag | input | 1 | Overcurrent comparator flag, asynchronous |
| brake | input | 1 | Brake request; masks overcurrent |
| drive_ok | output | 1 | Drive permitted to the commutation decoder |
| oc_latched | output | 1 | Overcurrent hold state |

## Verification
A wrong counter value changes the cycle on which `drive_ok` turns on within one sawtooth period, so the duty pattern drifts against a behavioural model right away. A hold that clears too early shows up as `drive_ok` returning before the next wrap or enable edge. A hold that sticks shows up as `drive_ok` staying low across a clearing edge that found overcurrent gone. An off-by-one in the synchronizer depth moves every enable and overcurrent response by a cycle. A comparison run on every clock catches each of these at the first cycle where it differs.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

   typedef struct packed {
      logic en_rise;
      logic saw_wrap;
   } clr_src_t;

   function automatic logic any_clear(input clr_src_t s);
      return s.en_rise | s.saw_wrap;
   endfunction

endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pwm_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/pwm_saw.sv
module pwm_saw #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   assign wrap = (cnt == TOP);

   assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP) |=> (cnt == '0));
   assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_oc_latch.sv
module pwm_oc_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic latched
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latched <= 1'b0;
      else if (set_req) latched <= 1'b1;
      else if (clr_req) latched <= 1'b0;
   end

   assert_set_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> latched);
   assert_hold_without_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && !clr_req) |=> latched);
   assert_release_on_clean_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && clr_req && !set_req) |=> !latched);
endmodule

// File: rtl/pwm_oc_gate.sv
module pwm_oc_gate
   import pwm_gate_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] speed_cmd,
   input  logic             enable_in,
   input  logic             oc_flag,
   input  logic             brake,
   output logic             drive_ok,
   output logic             oc_latched
);
   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_w
         $error("CNT_W out of range");
      end
   endgenerate

   logic             en_s, en_prev, oc_s, oc_live, saw_wrap;
   logic [CNT_W-1:0] saw;
   clr_src_t         clr;

   pwm_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
      .clk(clk), .rst_n(rst_n), .d(enable_in), .q(en_s));
   pwm_sync #(.STAGES(SYNC_STAGES)) u_oc_sync (
      .clk(clk), .rst_n(rst_n), .d(oc_flag), .q(oc_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_prev <= 1'b0;
      else        en_prev <= en_s;
   end

   pwm_saw #(.W(CNT_W)) u_saw (
      .clk(clk), .rst_n(rst_n), .cnt(saw), .wrap(saw_wrap));

   assign oc_live      = oc_s & ~brake;
   assign clr.en_rise  = en_s & ~en_prev;
   assign clr.saw_wrap = saw_wrap;

   pwm_oc_latch u_latch (
      .clk(clk), .rst_n(rst_n), .set_req(oc_live),
      .clr_req(any_clear(clr)), .latched(oc_latched));

   assign drive_ok = (speed_cmd < saw) & en_s & ~oc_latched & ~oc_live;

   assert_brake_masks_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (brake && !oc_latched && !en_s) |=> !oc_latched);
endmodule

// File: tb/sim_pwm_oc_gate.sv
module sim_pwm_oc_gate;
   localparam int W   = 8;
   localparam int TOP = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] speed_cmd = '0;
   logic         enable_in = 1'b0, oc_flag = 1'b0, brake = 1'b0;
   logic         drive_ok, oc_latched;

   int total = 0, bad = 0, cycles = 0;
   bit checking = 0;
   string tag = "R1";

   // reference model state
   int m_cnt = 0;
   bit m_e1 = 0, m_e2 = 0, m_ep = 0, m_o1 = 0, m_o2 = 0, m_lat = 0;

   always #2.5 clk = ~clk;

   pwm_oc_gate #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .speed_cmd(speed_cmd), .enable_in(enable_in),
      .oc_flag(oc_flag), .brake(brake), .drive_ok(drive_ok), .oc_latched(oc_latched));

   task automatic chk(input string r, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%b expected=%b at t=%0t", r, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit clear, live;
      cycles++;
      if (!rst_n) begin
         m_cnt = 0; m_e1 = 0; m_e2 = 0; m_ep = 0; m_o1 = 0; m_o2 = 0; m_lat = 0;
      end else begin
         live  = m_o2 && !brake;
         clear = (m_e2 && !m_ep) || (m_cnt == TOP);
         if (live) m_lat = 1;
         else if (clear) m_lat = 0;
         m_ep = m_e2; m_e2 = m_e1; m_e1 = enable_in;
         m_o2 = m_o1; m_o1 = oc_flag;
         m_cnt = (m_cnt + 1) % (TOP + 1);
      end
   end

   always @(negedge clk) begin
      bit exp_drive;
      if (checking) begin
         exp_drive = (int'(speed_cmd) < m_cnt) && m_e2 && !m_lat && !(m_o2 && !brake);
         chk(tag, "drive_ok", drive_ok, exp_drive);
         chk(tag, "oc_latched", oc_latched, m_lat);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   initial begin
      step(4);
      rst_n = 1'b1;
      @(negedge clk);
      tag = "R1";
      chk("R1", "reset drive_ok", drive_ok, 1'b0);
      chk("R1", "reset oc_latched", oc_latched, 1'b0);
      checking = 1;
      @(posedge clk); #1;

      tag = "R2"; enable_in = 1; speed_cmd = 8'd100; step(600);
      speed_cmd = 8'd7; step(300);
      tag = "R8"; speed_cmd = 8'd0; step(300);
      speed_cmd = 8'hFF; step(300);

      tag = "R3"; speed_cmd = 8'd50;
      for (int k = 0; k < 40; k++) begin
         enable_in = ~enable_in; step(3 + (k % 5));
      end
      enable_in = 1; step(20);

      tag = "R4"; speed_cmd = 8'd20;
      oc_flag = 1; step(1); oc_flag = 0; step(300);

      tag = "R5";
      step(40); oc_flag = 1; step(2); oc_flag = 0; step(6);
      enable_in = 0; step(4); enable_in = 1; step(40);

      tag = "R6";
      oc_flag = 1; step(600); oc_flag = 0; step(300);
      oc_flag = 1; step(10); enable_in = 0; step(3); enable_in = 1; step(5);
      oc_flag = 0; step(300);

      tag = "R7"; brake = 1;
      for (int k = 0; k < 10; k++) begin
         oc_flag = 1; step(5 + k); oc_flag = 0; step(17);
      end
      oc_flag = 1; step(30); brake = 0; step(10); oc_flag = 0; step(300);

      checking = 0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cycles > 100000);
      bad++; total++;
      $display("FAIL watchdog expired R1 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule